// File: doc/BRIEF.md
# Dual Stack Pointer Register Unit

This unit keeps the two 32-bit stack pointers of a processor core as a pair of physical registers: an active pointer that the datapath sees as A7, and a shadow pointer, OTHER_A7. The hardware gives neither register a fixed role. When the supervisor bit is 1, the active register holds the supervisor pointer and the shadow holds the user pointer. When the bit is 0, the roles are reversed. Whenever the mode bit changes and dual-pointer operation is enabled, the unit exchanges the contents of the two registers in a single clock. The active register therefore always belongs to the running mode.

With the enable bit clear, the core behaves as if it had one A7. Mode changes move nothing and the shadow register goes unused. Privileged move-to-USP and move-from-USP ports reach the shadow register, but only while the unit is in supervisor mode with the enable bit set. An attempt made under any other condition raises a privilege-violation flag and changes nothing. A debug port reads and writes either physical register by identity, with no remapping by mode.

The unit compares the mode input against the mode it registered on the previous clock, which is the mode the current register layout reflects. Privilege checks use that registered mode. Every write in a cycle lands in the registers as they are laid out before that cycle's exchange.

Top module: `dual_sp_unit`

## Requirements
- R1: After reset (synchronous, rst_n low at a clock edge), both registers read 0, the registered mode is supervisor and priv_viol_o is 0.
- R2: With dual_en_i = 1, a clock edge at which sup_mode_i differs from the registered mode exchanges the active and shadow contents, so A7 then holds the previous shadow value and the shadow holds the previous A7 value.
- R3: With dual_en_i = 0, a mode change leaves both registers unchanged.
- R4: dp_rd_data_o always shows the active register, and dp_wr_en_i writes dp_wr_data_i into it at the next edge.
- R5: When the registered mode is supervisor and dual_en_i = 1, usp_rd_data_o shows the shadow register and usp_wr_en_i writes usp_wr_data_i into the shadow register.
- R6: A USP access (usp_wr_en_i or usp_rd_en_i) made in user mode or with dual_en_i = 0 drives priv_viol_o = 1 in the same cycle. It reads as 0 and modifies neither register.
- R7: The debug port picks its register with dbg_sel_i (0 = active, 1 = shadow). The selection is the same in either mode, and a debug write lands in the selected register at the next edge.
- R8: A debug write to a register takes priority over a datapath write or USP write to that same register in the same cycle.
- R9: A write made in the cycle of an exchange lands in the register belonging to the old mode first, and the exchange follows. A datapath write in a swap cycle therefore ends up in the shadow register.
- R10: Privilege and the USP target are judged against the registered mode. A permitted USP write made in the same cycle as a change to user mode therefore ends up in A7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_mode_i | input | 1 | Supervisor mode bit (1 = supervisor) |
| dual_en_i | input | 1 | Dual stack pointer enable |
| dp_wr_en_i | input | 1 | Datapath A7 write strobe |
| dp_wr_data_i | input | DATA_W | Datapath A7 write value |
| dp_rd_data_o | output | DATA_W | Active register contents |
| usp_wr_en_i | input | 1 | Move-to-USP strobe |
| usp_wr_data_i | input | DATA_W | Move-to-USP value |
| usp_rd_en_i | input | 1 | Move-from-USP strobe |
| usp_rd_data_o | output | DATA_W | Move-from-USP result (0 when refused) |
| priv_viol_o | output | 1 | USP access refused |
| dbg_sel_i | input | 1 | Debug register select (0 active, 1 shadow) |
| dbg_wr_en_i | input | 1 | Debug write strobe |
| dbg_wr_data_i | input | DATA_W | Debug write value |
| dbg_rd_data_o | output | DATA_W | Selected physical register contents |

## Verification
The bench builds the unit with DATA_W = 32 and a reset mode of supervisor, which is the configuration the core uses. Full-width values with distinct upper and lower halves let the bench catch an exchange that moves only part of a word, as well as a write that lands in the wrong register. Supervisor reset puts the first mode fall within reach as a genuine swap. The bench also covers mode changes with the enable bit clear and writes that coincide with an exchange.

// File: rtl/sp_pkg.sv
// Package: shared encodings for the dual stack pointer unit.
// Assumes: a single clock domain; the debug select is one bit.
package sp_pkg;
    // Physical register slots; the debug port addresses them by these codes.
    typedef enum logic {
        SLOT_ACTIVE = 1'b0,
        SLOT_SHADOW = 1'b1
    } sp_slot_e;

    localparam int unsigned SP_SLOTS = 2;
endpackage

// File: rtl/sp_mode_tracker.sv
// Module: sp_mode_tracker
// Registers the supervisor bit and flags a swap when the incoming bit differs
// from the registered one while dual-pointer operation is enabled.
// Assumes: RST_SUP gives the mode the register layout reflects after reset.
module sp_mode_tracker #(
    parameter logic RST_SUP = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_mode_i,
    input  logic dual_en_i,
    output logic mode_q_o,
    output logic swap_o
);
    logic mode_q;

    // Follow the mode bit every cycle, enabled or not.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= RST_SUP;
        else        mode_q <= sup_mode_i;
    end

    // Request an exchange on a mode transition when enabled.
    always_comb swap_o = dual_en_i && (sup_mode_i != mode_q);

    assign mode_q_o = mode_q;

    AST_SWAP_FLIPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        swap_o |=> (mode_q != $past(mode_q))); // R10
endmodule

// File: rtl/sp_access_guard.sv
// Module: sp_access_guard
// Decides whether a USP access is allowed: only in registered supervisor mode
// with the enable bit set. A refused attempt raises the violation flag.
// Assumes: the strobes last one cycle per access.
module sp_access_guard (
    input  logic mode_q_i,
    input  logic dual_en_i,
    input  logic usp_wr_en_i,
    input  logic usp_rd_en_i,
    output logic usp_wr_ok_o,
    output logic usp_rd_ok_o,
    output logic priv_viol_o
);
    logic allowed;

    // Privilege test against the registered mode.
    always_comb begin
        allowed     = mode_q_i && dual_en_i;
        usp_wr_ok_o = usp_wr_en_i && allowed;
        usp_rd_ok_o = usp_rd_en_i && allowed;
        priv_viol_o = (usp_wr_en_i || usp_rd_en_i) && !allowed;
    end
endmodule

// File: rtl/sp_pair_regs.sv
// Module: sp_pair_regs
// Holds the two physical pointer registers. Writes apply first, and the
// optional exchange then crosses the written values.
// Assumes: at most one write source per slot per cycle (resolved upstream).
module sp_pair_regs
    import sp_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swap_i,
    input  logic [SP_SLOTS-1:0]             we_i,
    input  logic [SP_SLOTS-1:0][DATA_W-1:0] wd_i,
    output logic [SP_SLOTS-1:0][DATA_W-1:0] q_o
);
    logic [SP_SLOTS-1:0][DATA_W-1:0] pre_swap;
    logic [SP_SLOTS-1:0][DATA_W-1:0] slot_q;

    for (genvar s = 0; s < SP_SLOTS; s++) begin : g_slot
        // Merge this slot's write into its current value.
        always_comb pre_swap[s] = we_i[s] ? wd_i[s] : slot_q[s];

        // Load either own merged value or partner's on an exchange.
        always_ff @(posedge clk) begin
            if (!rst_n)      slot_q[s] <= '0;
            else if (swap_i) slot_q[s] <= pre_swap[SP_SLOTS-1-s];
            else             slot_q[s] <= pre_swap[s];
        end
    end

    assign q_o = slot_q;

    AST_SWAP_EXCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_i && we_i == '0) |=>
        (q_o[0] == $past(q_o[1]) && q_o[1] == $past(q_o[0]))); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap_i && we_i == '0) |=> $stable(q_o)); // R3
endmodule

// File: rtl/dual_sp_unit.sv
// Module: dual_sp_unit
// Top of the dual stack pointer unit. Arbitrates the datapath, USP and debug
// writes onto the two physical registers and drives the read ports.
// Assumes: debug writes outrank the other sources on the register they hit.
module dual_sp_unit
    import sp_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter logic        RST_SUP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sup_mode_i,
    input  logic              dual_en_i,
    input  logic              dp_wr_en_i,
    input  logic [DATA_W-1:0] dp_wr_data_i,
    output logic [DATA_W-1:0] dp_rd_data_o,
    input  logic              usp_wr_en_i,
    input  logic [DATA_W-1:0] usp_wr_data_i,
    input  logic              usp_rd_en_i,
    output logic [DATA_W-1:0] usp_rd_data_o,
    output logic              priv_viol_o,
    input  logic              dbg_sel_i,
    input  logic              dbg_wr_en_i,
    input  logic [DATA_W-1:0] dbg_wr_data_i,
    output logic [DATA_W-1:0] dbg_rd_data_o
);
    logic mode_q;
    logic swap;
    logic usp_wr_ok;
    logic usp_rd_ok;
    logic dbg_hit_act;
    logic dbg_hit_shd;
    logic [SP_SLOTS-1:0]             we;
    logic [SP_SLOTS-1:0][DATA_W-1:0] wd;
    logic [SP_SLOTS-1:0][DATA_W-1:0] q;

    sp_mode_tracker #(.RST_SUP(RST_SUP)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .sup_mode_i (sup_mode_i),
        .dual_en_i  (dual_en_i),
        .mode_q_o   (mode_q),
        .swap_o     (swap)
    );

    sp_access_guard u_guard (
        .mode_q_i    (mode_q),
        .dual_en_i   (dual_en_i),
        .usp_wr_en_i (usp_wr_en_i),
        .usp_rd_en_i (usp_rd_en_i),
        .usp_wr_ok_o (usp_wr_ok),
        .usp_rd_ok_o (usp_rd_ok),
        .priv_viol_o (priv_viol_o)
    );

    // Per-slot write select with debug first.
    always_comb begin
        dbg_hit_act = dbg_wr_en_i && (sp_slot_e'(dbg_sel_i) == SLOT_ACTIVE);
        dbg_hit_shd = dbg_wr_en_i && (sp_slot_e'(dbg_sel_i) == SLOT_SHADOW);
        we[SLOT_ACTIVE] = dbg_hit_act || dp_wr_en_i;
        wd[SLOT_ACTIVE] = dbg_hit_act ? dbg_wr_data_i : dp_wr_data_i;
        we[SLOT_SHADOW] = dbg_hit_shd || usp_wr_ok;
        wd[SLOT_SHADOW] = dbg_hit_shd ? dbg_wr_data_i : usp_wr_data_i;
    end

    sp_pair_regs #(.DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .swap_i (swap),
        .we_i   (we),
        .wd_i   (wd),
        .q_o    (q)
    );

    // Read ports: datapath, gated USP, raw debug.
    always_comb begin
        dp_rd_data_o  = q[SLOT_ACTIVE];
        usp_rd_data_o = usp_rd_ok ? q[SLOT_SHADOW] : '0;
        dbg_rd_data_o = q[dbg_sel_i];
    end

    AST_DP_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_wr_en_i && !dbg_wr_en_i && !swap) |=>
        (dp_rd_data_o == $past(dp_wr_data_i))); // R4
    AST_VIOL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_viol_o && !dbg_wr_en_i && !dp_wr_en_i && !swap) |=> $stable(q)); // R6
    AST_DISABLED_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_en_i && !dbg_wr_en_i && !dp_wr_en_i) |=> $stable(q)); // R3
    AST_DBG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_wr_en_i && !swap) |=> (dbg_rd_data_o == $past(dbg_wr_data_i)
                                    || dbg_sel_i != $past(dbg_sel_i))); // R8
endmodule

// File: tb/dual_sp_unit_bench.sv
module dual_sp_unit_bench;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup = 1'b1, en = 1'b0;
    logic dp_we = 1'b0, usp_we = 1'b0, usp_re = 1'b0, dbg_we = 1'b0, dbg_sel = 1'b0;
    logic [W-1:0] dp_wd = '0, usp_wd = '0, dbg_wd = '0;
    logic [W-1:0] dp_rd, usp_rd, dbg_rd;
    logic viol;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_sp_unit #(.DATA_W(W), .RST_SUP(1'b1)) u_dual_sp_unit (
        .clk(clk), .rst_n(rst_n), .sup_mode_i(sup), .dual_en_i(en),
        .dp_wr_en_i(dp_we), .dp_wr_data_i(dp_wd), .dp_rd_data_o(dp_rd),
        .usp_wr_en_i(usp_we), .usp_wr_data_i(usp_wd), .usp_rd_en_i(usp_re),
        .usp_rd_data_o(usp_rd), .priv_viol_o(viol), .dbg_sel_i(dbg_sel),
        .dbg_wr_en_i(dbg_we), .dbg_wr_data_i(dbg_wd), .dbg_rd_data_o(dbg_rd)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs change and samples occur 2 ns after it.
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        dp_we = 0; usp_we = 0; usp_re = 0; dbg_we = 0;
    endtask

    task automatic peek(input logic sel, output logic [W-1:0] v);
        dbg_sel = sel;
        #1;
        v = dbg_rd;
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        peek(1'b0, v); chk("R1 active", v, '0);
        peek(1'b1, v); chk("R1 shadow", v, '0);
        chk("R1 viol", {31'b0, viol}, '0);
    endtask

    task automatic t_dp_write();
        dp_we = 1; dp_wd = 32'hAAAA_0001;
        step(); idle();
        chk("R4 dp write", dp_rd, 32'hAAAA_0001);
    endtask

    task automatic t_usp_access();
        logic [W-1:0] v;
        en = 1; step();
        usp_we = 1; usp_wd = 32'h1234_5678;
        step(); idle();
        usp_re = 1; #1;
        chk("R5 usp read", usp_rd, 32'h1234_5678);
        chk("R5 no viol", {31'b0, viol}, '0);
        usp_re = 0;
        peek(1'b1, v); chk("R7 shadow raw", v, 32'h1234_5678);
        chk("R5 A7 untouched", dp_rd, 32'hAAAA_0001);
    endtask

    task automatic t_swap();
        sup = 0; step();
        chk("R2 A7 after swap", dp_rd, 32'h1234_5678);
        chk("R2 shadow after swap", dbg_rd, 32'hAAAA_0001);
        sup = 1; step();
        chk("R2 A7 back", dp_rd, 32'hAAAA_0001);
    endtask

    task automatic t_disabled();
        logic [W-1:0] v;
        en = 0; sup = 0; step();
        chk("R3 A7 held", dp_rd, 32'hAAAA_0001);
        peek(1'b1, v); chk("R3 shadow held", v, 32'h1234_5678);
        sup = 1; step();
        chk("R3 A7 held again", dp_rd, 32'hAAAA_0001);
    endtask

    task automatic t_violation();
        logic [W-1:0] v;
        en = 0; usp_re = 1; #1;
        chk("R6 viol disabled", {31'b0, viol}, 32'd1);
        chk("R6 read zero", usp_rd, '0);
        usp_re = 0;
        en = 1; sup = 0; step(); step();
        usp_we = 1; usp_wd = 32'hDEAD_BEEF; #1;
        chk("R6 viol user", {31'b0, viol}, 32'd1);
        step(); idle();
        peek(1'b1, v); chk("R6 shadow kept", v, 32'hAAAA_0001);
        chk("R6 A7 kept", dp_rd, 32'h1234_5678);
    endtask

    task automatic t_debug();
        logic [W-1:0] v;
        dbg_sel = 1; dbg_we = 1; dbg_wd = 32'h5555_0002;
        step(); idle();
        peek(1'b1, v); chk("R7 dbg shadow user mode", v, 32'h5555_0002);
        chk("R7 A7 untouched", dp_rd, 32'h1234_5678);
        dbg_sel = 0; dbg_we = 1; dbg_wd = 32'h0F0F_0003;
        dp_we = 1; dp_wd = 32'hFFFF_0004;
        step(); idle();
        chk("R8 dbg beats dp", dp_rd, 32'h0F0F_0003);
    endtask

    task automatic t_coincide();
        logic [W-1:0] v;
        sup = 1; step();
        chk("R2 A7 pre", dp_rd, 32'h5555_0002);
        sup = 0; dp_we = 1; dp_wd = 32'hCAFE_0005;
        step(); idle();
        chk("R9 A7 gets old shadow", dp_rd, 32'h0F0F_0003);
        peek(1'b1, v); chk("R9 shadow got write", v, 32'hCAFE_0005);
        sup = 1; step();
        usp_we = 1; usp_wd = 32'hBEEF_0006; sup = 0; #1;
        chk("R10 no viol at change", {31'b0, viol}, '0);
        step(); idle();
        chk("R10 usp write then swap", dp_rd, 32'hBEEF_0006);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        t_reset();
        t_dp_write();
        t_usp_access();
        t_swap();
        t_disabled();
        t_violation();
        t_debug();
        t_coincide();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule